// File: doc/BRIEF.md
# Current-Sense ADC Register Slave

This block is the digital control side of a 16-bit current-sense converter. It sits on a simple byte-wide register bus with an address, write data, write and read strobes, and registered read data. Through this bus, software finds identification bytes and sets the operating mode, trim, channel, decimation, settle delay and averaging fields. It also enables the peripheral, launches conversions, polls a two-bit status field and fetches the 16-bit result as two bytes.

A launched conversion runs an internal timer of `CONV_CYCLES` clock cycles. When the timer expires, the block latches the sample that the input port presents for the channel chosen at launch. It then raises end-of-conversion and emits a single-cycle interrupt pulse. The analog path, filtering and averaging are not modelled. The configuration fields for them are stored and read back only.

A reset-control byte is protected by a key. A key write must come directly before the write to that byte, and one key write admits a single write only.

Top module: `isense_adc_top`

## Requirements
- R1: Reads of 0x01, 0x04 and 0x05 return 0x01, 0x08 and 0x03. Any address without a register, including the key address 0xD0 and the request address 0x52, reads 0x00.
- R2: Configuration bytes read back as written: mode at 0x40, decimation parameters at 0x50, settle delay at 0x51 and averaging control at 0x5A. The channel byte at 0x48 keeps bits 2:0 only. The enable byte at 0x46 and the averaging-enable byte at 0x5B keep bit 7 only.
- R3: Writing 0x52 with bit 7 set while the enable bit is set starts a conversion. The status byte at 0x08 then reads 0x02 (bit 1 = pending, bit 0 = done clear). Once the conversion completes, it reads 0x01.
- R4: The output `eoc_irq` is high for exactly one clock cycle. That cycle follows the clock edge that comes `CONV_CYCLES` edges after the edge that accepted the request.
- R5: At completion, the result holds the 16-bit sample of the channel latched at request time. The sample for channel k sits on `samples[16k+15:16k]`. The result reads at 0x60 (bits 7:0) and 0x61 (bits 15:8), and later channel writes do not alter it.
- R6: A write to 0x52 with the enable bit clear, or with bit 7 of the data clear, is ignored. The status is unchanged and no interrupt occurs.
- R7: A new request after a finished conversion clears done and sets pending.
- R8: The reset-control byte at 0xDA accepts a write only if the immediately preceding write put 0xA5 to 0xD0. Any other write to 0xDA, including one after a wrong key value, is discarded. Bit 2 of this byte is the follow-warm-reset flag.
- R9: One key write admits one write to 0xDA only. Any other write in between cancels the key.
- R10: After reset, `eoc_irq` and `rdata` are 0, the status reads 0x00, and all writable bytes read 0x00.
- R11: `rdata` carries the addressed byte on the clock edge that samples `rd_en`, and reads 0x00 after an edge without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| samples | input | 128 | Eight 16-bit channel samples, channel k at bits 16k+15:16k |
| rdata | output | 8 | Registered read data |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Read data is due one edge after `rd_en` is sampled. Each bench read therefore raises the strobe across one edge and takes the value at the following falling edge. The interrupt is due `CONV_CYCLES` edges after the edge that accepted the request. The bench stamps that edge with its own cycle counter and compares the counted gap exactly; the falling edge after the pulse is then checked for the pulse being gone. Status and result bytes are read only after the pulse, apart from the pending check made on the first edge after the request.

// File: rtl/isense_adc_pkg.sv
package isense_adc_pkg;

    localparam int BYTE_W   = 8;
    localparam int CH_W     = 3;
    localparam int N_SLOTS  = 1 << CH_W;
    localparam int SMP_W    = 16;
    localparam int SMP_BUS_W = N_SLOTS * SMP_W;

    typedef logic [BYTE_W-1:0] byte_t;

    // register map
    localparam byte_t A_REV    = 8'h01;
    localparam byte_t A_TYPE   = 8'h04;
    localparam byte_t A_SUB    = 8'h05;
    localparam byte_t A_STAT   = 8'h08;
    localparam byte_t A_MODE   = 8'h40;
    localparam byte_t A_EN     = 8'h46;
    localparam byte_t A_CHSEL  = 8'h48;
    localparam byte_t A_DIG    = 8'h50;
    localparam byte_t A_SETTLE = 8'h51;
    localparam byte_t A_REQ    = 8'h52;
    localparam byte_t A_AVGC   = 8'h5A;
    localparam byte_t A_AVGE   = 8'h5B;
    localparam byte_t A_RES_LO = 8'h60;
    localparam byte_t A_RES_HI = 8'h61;
    localparam byte_t A_KEY    = 8'hD0;
    localparam byte_t A_PROT   = 8'hDA;

    localparam byte_t ID_REV   = 8'h01;
    localparam byte_t ID_TYPE  = 8'h08;
    localparam byte_t ID_SUB   = 8'h03;
    localparam byte_t KEY_CODE = 8'hA5;

    localparam int FLAG_BIT = 7;

    typedef struct packed {
        byte_t           mode;
        logic            enable;
        logic [CH_W-1:0] chsel;
        byte_t           dig;
        byte_t           settle;
        byte_t           avg_ctl;
        logic            avg_en;
    } cfg_t;

    typedef struct packed {
        logic pending;
        logic eoc;
    } conv_st_t;

    function automatic logic hit(input logic we, input byte_t a, input byte_t target);
        return we && (a == target);
    endfunction

    function automatic byte_t flag_byte(input logic f);
        byte_t b;
        b = '0;
        b[FLAG_BIT] = f;
        return b;
    endfunction

endpackage

// File: rtl/isense_cfg_regs.sv
module isense_cfg_regs
    import isense_adc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t addr,
    input  byte_t wdata,
    output cfg_t  cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (addr)
                A_MODE:   cfg.mode    <= wdata;
                A_EN:     cfg.enable  <= wdata[FLAG_BIT];
                A_CHSEL:  cfg.chsel   <= wdata[CH_W-1:0];
                A_DIG:    cfg.dig     <= wdata;
                A_SETTLE: cfg.settle  <= wdata;
                A_AVGC:   cfg.avg_ctl <= wdata;
                A_AVGE:   cfg.avg_en  <= wdata[FLAG_BIT];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/isense_key_guard.sv
module isense_key_guard
    import isense_adc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t addr,
    input  byte_t wdata,
    output logic  armed,
    output byte_t prot_q
);

    logic key_ok;
    logic prot_wr;

    assign key_ok  = hit(wr_en, addr, A_KEY) && (wdata == KEY_CODE);
    assign prot_wr = hit(wr_en, addr, A_PROT) && armed;

    // any write re-evaluates the key: only a correct key write leaves it armed
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (wr_en) begin
            armed <= key_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '0;
        end else if (prot_wr) begin
            prot_q <= wdata;
        end
    end

endmodule

// File: rtl/isense_conv_seq.sv
module isense_conv_seq
    import isense_adc_pkg::*;
#(
    parameter int CONV_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CH_W-1:0]      chan,
    input  logic [SMP_BUS_W-1:0] samples,
    output conv_st_t             st,
    output logic                 irq,
    output logic [SMP_W-1:0]     result
);

    localparam int CNT_W = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    logic [SMP_W-1:0] slot [N_SLOTS];
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0]  chan_q;
    logic             finish;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign slot[g] = samples[g*SMP_W +: SMP_W];
    end

    assign finish = st.pending && (cnt == '0) && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            cnt    <= '0;
            chan_q <= '0;
            irq    <= 1'b0;
            result <= '0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                st.pending <= 1'b1;
                st.eoc     <= 1'b0;
                cnt        <= CNT_LOAD;
                chan_q     <= chan;
            end else if (finish) begin
                st.pending <= 1'b0;
                st.eoc     <= 1'b1;
                irq        <= 1'b1;
                result     <= slot[chan_q];
            end else if (st.pending) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/isense_adc_top.sv
module isense_adc_top
    import isense_adc_pkg::*;
#(
    parameter int CONV_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           addr,
    input  logic [7:0]           wdata,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [SMP_BUS_W-1:0] samples,
    output logic [7:0]           rdata,
    output logic                 eoc_irq
);

    cfg_t             cfg;
    conv_st_t         conv_st;
    logic             armed;
    byte_t            prot_q;
    logic [SMP_W-1:0] result;
    logic             start;
    logic             cfg_en;
    byte_t            rd_mux;

    assign cfg_en = cfg.enable;
    assign start  = hit(wr_en, addr, A_REQ) && wdata[FLAG_BIT] && cfg.enable;

    isense_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cfg   (cfg)
    );

    isense_key_guard u_key (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .armed  (armed),
        .prot_q (prot_q)
    );

    isense_conv_seq #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .chan    (cfg.chsel),
        .samples (samples),
        .st      (conv_st),
        .irq     (eoc_irq),
        .result  (result)
    );

    always_comb begin
        case (addr)
            A_REV:    rd_mux = ID_REV;
            A_TYPE:   rd_mux = ID_TYPE;
            A_SUB:    rd_mux = ID_SUB;
            A_STAT:   rd_mux = {6'b0, conv_st.pending, conv_st.eoc};
            A_MODE:   rd_mux = cfg.mode;
            A_EN:     rd_mux = flag_byte(cfg.enable);
            A_CHSEL:  rd_mux = byte_t'(cfg.chsel);
            A_DIG:    rd_mux = cfg.dig;
            A_SETTLE: rd_mux = cfg.settle;
            A_AVGC:   rd_mux = cfg.avg_ctl;
            A_AVGE:   rd_mux = flag_byte(cfg.avg_en);
            A_RES_LO: rd_mux = result[7:0];
            A_RES_HI: rd_mux = result[15:8];
            A_PROT:   rd_mux = prot_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/isense_adc_chk.sv
module isense_adc_chk
    import isense_adc_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     wr_en,
    input byte_t    addr,
    input byte_t    wdata,
    input logic     irq,
    input conv_st_t st,
    input logic     enable,
    input logic     armed,
    input byte_t    prot
);

    // R3: pending and done never both set
    a_r3_status_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(st.pending && st.eoc));

    // R4: pulse is one cycle wide
    a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R4: pulse coincides with a finished, non-pending status
    a_r4_irq_with_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st.eoc && !st.pending));

    // R6: request with enable clear leaves an idle block idle
    a_r6_disabled_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_REQ && !enable && !st.pending) |=> !st.pending);

    // R7: accepted request clears done and sets pending
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_REQ && wdata[FLAG_BIT] && enable) |=> (st.pending && !st.eoc));

    // R8: protected byte changes only on an armed write to its address
    a_r8_prot_guard: assert property (@(posedge clk) disable iff (rst)
        (prot != $past(prot)) |-> ($past(armed) && $past(wr_en) && $past(addr) == A_PROT));

    // R9: key is armed only right after a correct key write
    a_r9_armed_source: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(wr_en) && $past(addr) == A_KEY && $past(wdata) == KEY_CODE));

endmodule

bind isense_adc_top isense_adc_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .irq    (eoc_irq),
    .st     (conv_st),
    .enable (cfg_en),
    .armed  (armed),
    .prot   (prot_q)
);

// File: tb/isense_adc_top_tb_top.sv
module isense_adc_top_tb_top;

    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [127:0] samples = '0;
    logic [7:0]   rdata;
    logic         eoc_irq;

    int  n_checks = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  wr_cyc = 0;
    bit  finished = 1'b0;

    // {channel[2:0], sample[15:0]}
    localparam logic [18:0] VEC [6] = '{
        {3'd0, 16'h1234},
        {3'd1, 16'hBEEF},
        {3'd3, 16'h00FF},
        {3'd5, 16'hFF00},
        {3'd6, 16'h8001},
        {3'd7, 16'h5A5A}
    };

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    isense_adc_top #(.CONV_CYCLES(N)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .samples (samples),
        .rdata   (rdata),
        .eoc_irq (eoc_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wr_cyc = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, {8'h00, d}, {8'h00, exp});
    endtask

    task automatic set_samples(input logic [2:0] ch, input logic [15:0] v);
        for (int k = 0; k < 8; k++)
            samples[k*16 +: 16] = (k == int'(ch)) ? v : (~v ^ 16'(k));
    endtask

    // wait for the pulse; returns the gap from the request edge, -1 if none
    task automatic wait_irq(output int gap);
        gap = -1;
        for (int i = 0; i < N + 8; i++) begin
            @(negedge clk);
            if (eoc_irq) begin
                gap = cyc - wr_cyc;
                break;
            end
        end
    endtask

    initial begin
        int gap;
        logic [7:0] d;

        // R10 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 irq after reset", {15'b0, eoc_irq}, 16'h0);
        check("R10 rdata after reset", {8'h00, rdata}, 16'h0);
        rd_chk("R10 status", 8'h08, 8'h00);
        rd_chk("R10 mode", 8'h40, 8'h00);
        rd_chk("R10 prot", 8'hDA, 8'h00);

        // R1 identification and unmapped
        rd_chk("R1 rev", 8'h01, 8'h01);
        rd_chk("R1 type", 8'h04, 8'h08);
        rd_chk("R1 subtype", 8'h05, 8'h03);
        rd_chk("R1 unmapped 0x02", 8'h02, 8'h00);
        rd_chk("R1 unmapped 0x70", 8'h70, 8'h00);
        rd_chk("R1 key addr", 8'hD0, 8'h00);

        // R11 rdata clears after an edge without rd_en
        @(negedge clk);
        check("R11 idle rdata", {8'h00, rdata}, 16'h0);

        // R2 configuration readback
        wr(8'h40, 8'h5B); rd_chk("R2 mode", 8'h40, 8'h5B);
        wr(8'h46, 8'hFF); rd_chk("R2 enable", 8'h46, 8'h80);
        wr(8'h48, 8'hFE); rd_chk("R2 chsel", 8'h48, 8'h06);
        wr(8'h50, 8'h0C); rd_chk("R2 dig", 8'h50, 8'h0C);
        wr(8'h51, 8'h33); rd_chk("R2 settle", 8'h51, 8'h33);
        wr(8'h5A, 8'h02); rd_chk("R2 avg ctl", 8'h5A, 8'h02);
        wr(8'h5B, 8'h7F); rd_chk("R2 avg en", 8'h5B, 8'h00);
        wr(8'h5B, 8'h80); rd_chk("R2 avg en set", 8'h5B, 8'h80);

        // R6 request ignored with enable clear, or bit 7 clear
        wr(8'h46, 8'h00);
        wr(8'h52, 8'h80);
        wait_irq(gap);
        check("R6 no irq when disabled", 16'(gap), 16'hFFFF);
        rd_chk("R6 status when disabled", 8'h08, 8'h00);
        wr(8'h46, 8'h80);
        wr(8'h52, 8'h7F);
        wait_irq(gap);
        check("R6 no irq without bit 7", 16'(gap), 16'hFFFF);
        rd_chk("R6 status without bit 7", 8'h08, 8'h00);
        rd_chk("R1 request addr reads zero", 8'h52, 8'h00);

        // R3 R4 R5 R7 vector walk
        foreach (VEC[i]) begin
            logic [2:0]  ch;
            logic [15:0] v;
            ch = VEC[i][18:16];
            v  = VEC[i][15:0];
            wr(8'h48, {5'b0, ch});
            set_samples(ch, v);
            wr(8'h52, 8'h80);
            begin
                int c0;
                c0 = wr_cyc;
                rd_chk("R3 R7 pending after request", 8'h08, 8'h02);
                wr_cyc = c0;
            end
            wait_irq(gap);
            check("R4 irq latency", 16'(gap), 16'(N));
            @(negedge clk);
            check("R4 irq one cycle", {15'b0, eoc_irq}, 16'h0);
            rd_chk("R3 done status", 8'h08, 8'h01);
            rd_chk("R5 result low", 8'h60, v[7:0]);
            rd_chk("R5 result high", 8'h61, v[15:8]);
        end

        // R5 channel latched at request; later channel write does not matter
        wr(8'h48, 8'h01);
        set_samples(3'd1, 16'hC3A7);
        wr(8'h52, 8'h80);
        begin
            int c0;
            c0 = wr_cyc;
            wr(8'h48, 8'h05);
            wr_cyc = c0;
        end
        wait_irq(gap);
        check("R4 irq latency latched", 16'(gap), 16'(N));
        rd_chk("R5 latched channel low", 8'h60, 8'hA7);
        rd_chk("R5 latched channel high", 8'h61, 8'hC3);

        // R8 R9 protected register
        wr(8'hDA, 8'hFF);
        rd_chk("R8 write without key", 8'hDA, 8'h00);
        wr(8'hD0, 8'hA5); wr(8'hDA, 8'h04);
        rd_chk("R8 keyed write warm flag", 8'hDA, 8'h04);
        wr(8'hDA, 8'hFF);
        rd_chk("R9 key single use", 8'hDA, 8'h04);
        wr(8'hD0, 8'hA5); wr(8'h40, 8'h00); wr(8'hDA, 8'h00);
        rd_chk("R9 key cancelled by other write", 8'hDA, 8'h04);
        wr(8'hD0, 8'h5A); wr(8'hDA, 8'h00);
        rd_chk("R8 wrong key", 8'hDA, 8'h04);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule